// File: doc/BRIEF.md
# Masked-Trigger Logic Analyzer Capture Core

This block is an on-chip logic-analyzer capture engine. Every clock it can store a data word and a separate trigger word, each in its own circular buffer of 1024 entries. A trigger event fires when the trigger word, ANDed with a mask, equals a compare value. Software sets both the mask and the compare value through the register port while the chip runs, so the trigger condition changes without rebuilding the hardware. If the mask is all ones, the test is a plain equality match. A user who needs a single-bit trigger ties the other trigger bits to a constant.

After a trigger, capture runs for a programmable holdoff count of further samples and then freezes. Software then reads the frozen buffers back, oldest entry first, through a data port whose read pointer advances on each read. Software can also force a trigger without the comparator. A re-arm write restarts capture and takes the current holdoff value, so the holdoff can be changed during a run. All registers sit behind a simple Wishbone-style port with a one-cycle acknowledge.

Top module: `la_capture`

## Requirements
- R1: After reset the status word (address 1) reads 0, the control word (address 0) reads 0 and the trigger address (address 5) reads 0.
- R2: With the mask at all ones and compare enable set, the first armed sample whose trigger word equals the compare value is the trigger sample. Its buffered data and trigger words appear in the readout.
- R3: Only trigger bits where the mask is 1 take part in the compare. Masked-out bits never prevent a match.
- R4: Every stored entry holds the trigger word seen in the same cycle as its data word, in a separate buffer read at address 7 at the current read position. Reading address 7 does not advance the pointer.
- R5: After the trigger sample, exactly H further samples are stored, where H is the holdoff latched at arm time. H = 0 stops right after the trigger sample.
- R6: Once capture stops, the buffers and write pointer stay frozen until the next arm, and status reads 6 (bit 0 armed, bit 1 triggered, bit 2 stopped).
- R7: Readout at address 6 starts at the oldest entry and advances the read pointer by one per read, wrapping modulo 1024, so read 1025 returns the same word as read 1.
- R8: Writing control bit 1 forces a trigger on the sample stored in the cycle after the write. Compare matches are ignored while control bit 2 (compare enable) is 0.
- R9: Only the first trigger after arming counts. Later matches before the next arm leave the capture unchanged.
- R10: Each bus access is acknowledged exactly one cycle after the request. Compare (address 2), mask (address 3) and holdoff (address 4) read back what was written.
- R11: A control write with bit 0 set re-arms capture from any state, restarts the buffer at index 0 and loads the current holdoff register, so a holdoff rewritten during a run applies to the new run.
- R12: The trigger address register holds the buffer index of the trigger sample. Index 0 is the first sample stored after arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleData | input | DATA_W | Data word captured each active cycle |
| trigWord | input | TRIG_W | Trigger word compared and captured each active cycle |
| busCyc | input | 1 | Bus cycle valid |
| busStb | input | 1 | Bus strobe |
| busWe | input | 1 | Bus write enable |
| busAddr | input | 3 | Register word address |
| busWdat | input | 32 | Bus write data |
| busRdat | output | 32 | Bus read data, valid with acknowledge |
| busAck | output | 1 | One-cycle acknowledge |

## Verification
The bench checks that the frozen readout is gap-free and ordered. A design that mis-counts holdoff, or records the trigger one cycle late, would produce a wrong newest value or a trigger entry at the wrong position. The masked test matches on an aligned block of 4096 values. Lost mask bits would fire early, and a re-trigger bug would move the capture window forward. A compare-disabled run holds a matching value in its window: a design that ignores the enable would stop before the manual trigger. A mid-run holdoff rewrite plus re-arm with H = 0 exposes both a design that keeps the old holdoff and an off-by-one in the stop.

// File: rtl/la_pkg.sv
package la_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_STAT  = 3'd1,
    REG_CMP   = 3'd2,
    REG_MASK  = 3'd3,
    REG_HOLD  = 3'd4,
    REG_TADDR = 3'd5,
    REG_DATA  = 3'd6,
    REG_TWORD = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ARMED, ST_POST, ST_STOP
  } cap_state_e;

  typedef struct packed {
    logic ptrClr;
    logic capWr;
    logic latchTrig;
    logic loadRd;
    logic rdInc;
  } cap_strobe_t;
endpackage

// File: rtl/la_datapath.sv
module la_datapath
  import la_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TRIG_W = 32,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cap_strobe_t       strobe,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [TRIG_W-1:0] trigWord,
  input  logic [TRIG_W-1:0] cmpVal,
  input  logic [TRIG_W-1:0] maskVal,
  output logic              match,
  output logic [BUS_W-1:0]  rdWord,
  output logic [BUS_W-1:0]  rdTrigWord,
  output logic [BUS_W-1:0]  trigAddrWord
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [TRIG_W-1:0] trigMem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr, trigAddr;

  assign match        = (trigWord & maskVal) == cmpVal;
  assign rdWord       = BUS_W'(dataMem[rdPtr]);
  assign rdTrigWord   = BUS_W'(trigMem[rdPtr]);
  assign trigAddrWord = BUS_W'(trigAddr);

  always_ff @(posedge clk) begin
    if (strobe.capWr && !strobe.ptrClr) begin
      dataMem[wrPtr] <= sampleData;
      trigMem[wrPtr] <= trigWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      trigAddr <= '0;
    end else if (strobe.ptrClr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.capWr)     wrPtr    <= wrPtr + 1'b1;
      if (strobe.latchTrig) trigAddr <= wrPtr;
      if (strobe.loadRd)    rdPtr    <= wrPtr;
      else if (strobe.rdInc) rdPtr   <= rdPtr + 1'b1;
    end
  end

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capWr && !strobe.ptrClr) |=> wrPtr == AW'($past(wrPtr) + 1'b1));

  assert_read_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRd && !strobe.ptrClr) |=> rdPtr == $past(wrPtr));
endmodule

// File: rtl/la_ctrl.sv
module la_ctrl
  import la_pkg::*;
#(
  parameter int TRIG_W = 32,
  parameter int HOLD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic [2:0]        busAddr,
  input  logic [BUS_W-1:0]  busWdat,
  output logic [BUS_W-1:0]  busRdat,
  output logic              busAck,
  input  logic              match,
  input  logic [BUS_W-1:0]  rdWord,
  input  logic [BUS_W-1:0]  rdTrigWord,
  input  logic [BUS_W-1:0]  trigAddrWord,
  output cap_strobe_t       strobe,
  output logic [TRIG_W-1:0] cmpVal,
  output logic [TRIG_W-1:0] maskVal
);
  cap_state_e        state;
  reg_sel_e          sel;
  logic [HOLD_W-1:0] holdReg, holdCnt;
  logic              cmpEn, manualQ, req, armWr, fire;
  logic [BUS_W-1:0]  statWord, rdMux;

  assign sel   = reg_sel_e'(busAddr);
  assign req   = busCyc & busStb & ~busAck;
  assign armWr = req & busWe & (sel == REG_CTRL) & busWdat[0];
  assign fire  = (state == ST_ARMED) && ((cmpEn && match) || manualQ);
  assign statWord = {29'd0, state == ST_STOP,
                     (state == ST_POST) || (state == ST_STOP), state == ST_ARMED};

  always_comb begin
    strobe.ptrClr    = armWr;
    strobe.capWr     = (state == ST_ARMED) || (state == ST_POST && holdCnt != '0);
    strobe.latchTrig = fire;
    strobe.loadRd    = (state == ST_POST) && (holdCnt == '0);
    strobe.rdInc     = req & ~busWe & (sel == REG_DATA);
  end

  always_comb begin
    case (sel)
      REG_CTRL:  rdMux = {29'd0, cmpEn, 2'b00};
      REG_STAT:  rdMux = statWord;
      REG_CMP:   rdMux = BUS_W'(cmpVal);
      REG_MASK:  rdMux = BUS_W'(maskVal);
      REG_HOLD:  rdMux = BUS_W'(holdReg);
      REG_TADDR: rdMux = trigAddrWord;
      REG_DATA:  rdMux = rdWord;
      default:   rdMux = rdTrigWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAck  <= 1'b0;
      busRdat <= '0;
      cmpVal  <= '0;
      maskVal <= '0;
      holdReg <= '0;
      cmpEn   <= 1'b0;
      manualQ <= 1'b0;
    end else begin
      busAck  <= req;
      manualQ <= req & busWe & (sel == REG_CTRL) & busWdat[1];
      if (req && !busWe) busRdat <= rdMux;
      if (req && busWe) begin
        case (sel)
          REG_CTRL: cmpEn   <= busWdat[2];
          REG_CMP:  cmpVal  <= busWdat[TRIG_W-1:0];
          REG_MASK: maskVal <= busWdat[TRIG_W-1:0];
          REG_HOLD: holdReg <= busWdat[HOLD_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else if (armWr) begin
      state   <= ST_ARMED;
      holdCnt <= holdReg;
    end else begin
      case (state)
        ST_ARMED: if (fire) state <= ST_POST;
        ST_POST:  if (holdCnt == '0) state <= ST_STOP;
                  else holdCnt <= holdCnt - 1'b1;
        default: ;
      endcase
    end
  end

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  assert_stop_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && !armWr) |=> state == ST_STOP);

  assert_arm_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ARMED) |-> $past(armWr));

  assert_single_trigger_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST && !armWr) |=> state != ST_ARMED);
endmodule

// File: rtl/la_capture.sv
module la_capture
  import la_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TRIG_W = 32,
  parameter int DEPTH  = 1024,
  parameter int HOLD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [TRIG_W-1:0] trigWord,
  input  logic              busCyc,
  input  logic              busStb,
  input  logic              busWe,
  input  logic [2:0]        busAddr,
  input  logic [31:0]       busWdat,
  output logic [31:0]       busRdat,
  output logic              busAck
);
  cap_strobe_t       strobe;
  logic [TRIG_W-1:0] cmpVal, maskVal;
  logic              match;
  logic [BUS_W-1:0]  rdWord, rdTrigWord, trigAddrWord;

  la_ctrl #(.TRIG_W(TRIG_W), .HOLD_W(HOLD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
    .busAddr(busAddr), .busWdat(busWdat), .busRdat(busRdat), .busAck(busAck),
    .match(match), .rdWord(rdWord), .rdTrigWord(rdTrigWord),
    .trigAddrWord(trigAddrWord), .strobe(strobe), .cmpVal(cmpVal), .maskVal(maskVal)
  );

  la_datapath #(.DATA_W(DATA_W), .TRIG_W(TRIG_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleData(sampleData),
    .trigWord(trigWord), .cmpVal(cmpVal), .maskVal(maskVal), .match(match),
    .rdWord(rdWord), .rdTrigWord(rdTrigWord), .trigAddrWord(trigAddrWord)
  );
endmodule

// File: tb/la_capture_bench.sv
`timescale 1ns/1ps
module la_capture_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cnt = 32'd0;
  logic        busCyc = 1'b0, busStb = 1'b0, busWe = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWdat = 32'd0;
  logic [31:0] busRdat;
  logic        busAck;

  int errors = 0;
  int checks = 0;
  logic [31:0] lastReqCnt;
  logic [31:0] dw [1024];
  logic [31:0] tw [1024];

  always #10 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 1;

  la_capture u_la_capture (
    .clk(clk), .rstN(rstN), .sampleData(cnt), .trigWord(cnt),
    .busCyc(busCyc), .busStb(busStb), .busWe(busWe), .busAddr(busAddr),
    .busWdat(busWdat), .busRdat(busRdat), .busAck(busAck)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busAccess(input bit we, input logic [2:0] a, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    busCyc = 1'b1; busStb = 1'b1; busWe = we; busAddr = a; busWdat = wd;
    @(posedge clk);
    #1 lastReqCnt = cnt;
    @(negedge clk);
    rd = busRdat;
    if (!busAck) begin errors++; $display("FAIL R10 ack missing actual=0 expected=1"); end
    busCyc = 1'b0; busStb = 1'b0; busWe = 1'b0;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] wd);
    logic [31:0] dummy;
    busAccess(1'b1, a, wd, dummy);
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] rd);
    busAccess(1'b0, a, 32'd0, rd);
  endtask

  task automatic waitStop();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      busRead(3'd1, s);
      if (s[2]) break;
    end
  endtask

  task automatic readAll();
    for (int i = 0; i < 1024; i++) begin
      busRead(3'd7, tw[i]);
      busRead(3'd6, dw[i]);
    end
  endtask

  // Frozen readout: v = trigger sample value, h = holdoff, armCnt = sample at the arm edge
  task automatic verifyCapture(input string tag, input logic [31:0] v, input int h, input logic [31:0] armCnt);
    int badOrder = 0, badPair = 0;
    logic [31:0] s, ta, again;
    for (int i = 1; i < 1024; i++) if (dw[i] != dw[i-1] + 1) badOrder++;
    for (int i = 0; i < 1024; i++) if (tw[i] != dw[i]) badPair++;
    chk(badOrder == 0, {tag, " R7 oldest-first order"}, badOrder, 0);
    chk(badPair == 0, {tag, " R4 trigger buffer alongside data"}, badPair, 0);
    chk(dw[1023] == v + h, {tag, " R5 newest entry"}, dw[1023], v + h);
    chk(tw[1023-h] == v, {tag, " R2 trigger entry"}, tw[1023-h], v);
    busRead(3'd5, ta);
    chk(ta == ((v - armCnt - 1) & 32'h3FF), {tag, " R12 trigger address"}, ta, (v - armCnt - 1) & 32'h3FF);
    busRead(3'd6, again);
    chk(again == dw[0], {tag, " R7 wrap to oldest"}, again, dw[0]);
    busRead(3'd1, s);
    chk(s == 32'd6, {tag, " R6 stopped status"}, s, 32'd6);
  endtask

  task automatic testReset();
    logic [31:0] r;
    busRead(3'd1, r); chk(r == 0, "R1 status after reset", r, 0);
    busRead(3'd0, r); chk(r == 0, "R1 control after reset", r, 0);
    busRead(3'd5, r); chk(r == 0, "R1 trigger address after reset", r, 0);
  endtask

  task automatic testEquality();
    logic [31:0] v, r, armCnt;
    busWrite(3'd3, 32'hFFFF_FFFF);
    busWrite(3'd4, 32'd10);
    v = cnt + 1500;
    busWrite(3'd2, v);
    busRead(3'd2, r); chk(r == v, "R10 compare readback", r, v);
    busRead(3'd3, r); chk(r == 32'hFFFF_FFFF, "R10 mask readback", r, 32'hFFFF_FFFF);
    busRead(3'd4, r); chk(r == 32'd10, "R10 holdoff readback", r, 32'd10);
    @(negedge clk); chk(busAck == 1'b0, "R10 ack lasts one cycle", busAck, 0);
    busWrite(3'd0, 32'h5);
    armCnt = lastReqCnt;
    busRead(3'd1, r); chk(r == 32'd1, "R11 armed status", r, 1);
    waitStop();
    repeat (200) @(negedge clk);
    readAll();
    verifyCapture("equality", v, 10, armCnt);
  endtask

  task automatic testMask();
    logic [31:0] target, armCnt;
    target = (cnt + 32'd1300 + 32'd4095) & 32'hFFFF_F000;
    busWrite(3'd3, 32'hFFFF_F000);
    busWrite(3'd2, target);
    busWrite(3'd4, 32'd5);
    busWrite(3'd0, 32'h5);
    armCnt = lastReqCnt;
    waitStop();
    readAll();
    // R3: low 12 bits masked; R9: the 4095 later matches are ignored
    verifyCapture("mask R3 R9", target, 5, armCnt);
  endtask

  task automatic testManual();
    logic [31:0] r, armCnt, manCnt;
    busWrite(3'd3, 32'hFFFF_FFFF);
    busWrite(3'd2, cnt + 300);
    busWrite(3'd4, 32'd3);
    busWrite(3'd0, 32'h1);
    armCnt = lastReqCnt;
    repeat (1500) @(negedge clk);
    busRead(3'd1, r); chk(r == 32'd1, "R8 disabled compare ignored", r, 1);
    busWrite(3'd0, 32'h2);
    manCnt = lastReqCnt;
    waitStop();
    readAll();
    verifyCapture("manual R8", manCnt + 1, 3, armCnt);
  endtask

  task automatic testRearm();
    logic [31:0] v, r, armCnt;
    busWrite(3'd3, 32'hFFFF_FFFF);
    busWrite(3'd4, 32'd50);
    busWrite(3'd2, cnt + 32'd100000);
    busWrite(3'd0, 32'h5);
    repeat (200) @(negedge clk);
    busWrite(3'd4, 32'd0);
    v = cnt + 1500;
    busWrite(3'd2, v);
    busWrite(3'd0, 32'h5);
    armCnt = lastReqCnt;
    busRead(3'd1, r); chk(r == 32'd1, "R11 re-armed status", r, 1);
    waitStop();
    readAll();
    verifyCapture("rearm R11 holdoff zero", v, 0, armCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEquality();
    testMask();
    testManual();
    testRearm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule